// File: doc/BRIEF.md
# Monitor-Wait Address Watch Unit

This unit lets a processor core park itself until another agent takes ownership of one cache line. A monitor command arms the unit and records the virtual address being watched. A later wait command brings the translated physical address of that location. The unit keeps the line-aligned form of that address, asks the core to halt, and asks for an 8-byte read of the watched location. The unit then compares every snooped or invalidated line address against the stored one. An exact hit while the unit is armed and waiting produces a single-cycle wakeup.

A wakeup that has not yet been consumed is kept in a sticky pending flag. The next wait command consumes that flag instead of parking the core, so a wakeup that arrives before the wait is not lost. Within one cycle the commands take effect in a fixed order: monitor first, then wait, then the snoop compare.

The controller is a four-state machine on the {waiting, armed} pair. `ST_IDLE` means not armed and not waiting. `ST_ARMED` means armed but not waiting. `ST_PARKED` means waiting without being armed, which no snoop can wake. `ST_SLEEP` means armed and waiting, the only state that a snoop can wake. There are three transitions. *Arm* (monitor command) sets armed from any state. *Park* (a wait while no wakeup is pending) sets waiting. *Wake* (matching snoop) leaves `ST_SLEEP` for `ST_ARMED`. Reset enters `ST_IDLE`.

Top module: `mw_watch_unit`

## Requirements
- R1: After reset, is_armed, is_waiting, wake_pending, halt_req, wake_pulse and fetch_req are 0, and line_addr and fetch_vaddr are 0.
- R2: A monitor command (mon_valid=1) sets is_armed, stores mon_vaddr so that it appears on fetch_vaddr, and clears line_addr to 0. It does not change is_waiting. The effects are visible after the next rising edge.
- R3: When a wait command stores an address, line_addr becomes wait_paddr with its low log2(LINE_BYTES) bits forced to 0. The default LINE_BYTES is 64, so bits [5:0] are forced to 0.
- R4: A wait command (wait_valid=1) with wake_pending=0 stores the line address and sets is_waiting. halt_req is 1 for exactly the following cycle.
- R5: A wait command with wake_pending=1 clears wake_pending and leaves is_waiting and line_addr unchanged. halt_req stays 0.
- R6: A snoop wakes the core only if snoop_valid=1, the unit is armed and waiting, and snoop_addr equals line_addr in all AW bits. An address inside the same line but not aligned to it does not wake the core. An unarmed unit is not woken. A matching address with snoop_valid=0 does not wake the core.
- R7: A waking snoop clears is_waiting and raises wake_pulse for exactly one cycle. is_armed stays 1.
- R8: Every wakeup sets wake_pending.
- R9: Commands in one cycle take effect in the order monitor, wait, snoop. A wait and a matching snoop in the same cycle give halt_req and wake_pulse together. A monitor, a wait and a matching snoop in the same cycle also wake the core.
- R10: Every wait command gives fetch_req=1 in the following cycle. fetch_vaddr then holds the monitored virtual address, and fetch_len is 8 (the byte count of the read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_valid | input | 1 | Monitor command |
| mon_vaddr | input | AW | Virtual address to watch |
| wait_valid | input | 1 | Wait command |
| wait_paddr | input | AW | Translated physical address for the wait |
| snoop_valid | input | 1 | Snoop or invalidation present |
| snoop_addr | input | AW | Snooped line address |
| halt_req | output | 1 | One-cycle request to halt the core |
| wake_pulse | output | 1 | One-cycle wakeup to the core |
| fetch_req | output | 1 | One-cycle read request issued by a wait |
| fetch_vaddr | output | AW | Monitored virtual address (read address) |
| fetch_len | output | $clog2(FETCH_BYTES)+1 | Read length in bytes |
| is_armed | output | 1 | Armed flag |
| is_waiting | output | 1 | Waiting flag |
| wake_pending | output | 1 | Unconsumed-wakeup flag |
| line_addr | output | AW | Stored physical line address |

## Verification
A behavioural model in the bench runs alongside the design and is compared with it on every clock. Directed sequences cover several cases. Snoops to the exact line are told apart from snoops to an unaligned byte in that line, to a neighbouring line, and from matching addresses with snoop_valid low. A wait with no wakeup pending is told apart from one that consumes a pending wakeup. Same-cycle combinations of monitor, wait and snoop show whether the monitor-wait-snoop order holds, including the zeroed line left by a monitor. A long pseudo-random phase then draws addresses from a four-entry pool, so that hits, misses and command collisions are frequent.

// File: rtl/mw_pkg.sv
package mw_pkg;

    // State bit 0 = armed, bit 1 = waiting.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ARMED  = 2'b01,
        ST_PARKED = 2'b10,
        ST_SLEEP  = 2'b11
    } mw_state_e;

    function automatic mw_state_e mw_make(input logic armed, input logic waiting);
        mw_state_e s;
        unique case ({waiting, armed})
            2'b00:   s = ST_IDLE;
            2'b01:   s = ST_ARMED;
            2'b10:   s = ST_PARKED;
            default: s = ST_SLEEP;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mw_line_align.sv
module mw_line_align #(
    parameter int AW         = 48,
    parameter int LINE_BYTES = 64
) (
    input  logic [AW-1:0] byte_addr,
    output logic [AW-1:0] line_base
);
    localparam int OFF = $clog2(LINE_BYTES);

    generate
        if (OFF == 0) begin : g_noalign
            assign line_base = byte_addr;
        end else begin : g_align
            assign line_base = {byte_addr[AW-1:OFF], {OFF{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/mw_snoop_cmp.sv
module mw_snoop_cmp #(
    parameter int AW = 48
) (
    input  logic          probe_valid,
    input  logic          watch_live,
    input  logic [AW-1:0] probe_addr,
    input  logic [AW-1:0] watch_addr,
    output logic          hit
);
    logic same;
    assign same = (probe_addr == watch_addr);
    assign hit  = probe_valid & watch_live & same;
endmodule

// File: rtl/mw_ctrl_fsm.sv
module mw_ctrl_fsm
    import mw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      arm_cmd,
    input  logic      park_cmd,
    input  logic      wake_hit,
    output mw_state_e state_q,
    output logic      armed_eff,
    output logic      waiting_eff
);
    mw_state_e state_d;
    logic      armed_now;
    logic      waiting_now;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Decode current state
    always_comb begin
        unique case (state_q)
            ST_IDLE:   begin armed_now = 1'b0; waiting_now = 1'b0; end
            ST_ARMED:  begin armed_now = 1'b1; waiting_now = 1'b0; end
            ST_PARKED: begin armed_now = 1'b0; waiting_now = 1'b1; end
            ST_SLEEP:  begin armed_now = 1'b1; waiting_now = 1'b1; end
            default:   begin armed_now = 1'b0; waiting_now = 1'b0; end
        endcase
    end

    // Arm, then park, then wake
    assign armed_eff   = armed_now | arm_cmd;
    assign waiting_eff = waiting_now | park_cmd;

    always_comb begin
        state_d = mw_make(armed_eff, waiting_eff & ~wake_hit);
    end
endmodule

// File: rtl/mw_watch_unit.sv
module mw_watch_unit
    import mw_pkg::*;
#(
    parameter int AW          = 48,
    parameter int LINE_BYTES  = 64,
    parameter int FETCH_BYTES = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mon_valid,
    input  logic [AW-1:0]                mon_vaddr,
    input  logic                         wait_valid,
    input  logic [AW-1:0]                wait_paddr,
    input  logic                         snoop_valid,
    input  logic [AW-1:0]                snoop_addr,
    output logic                         halt_req,
    output logic                         wake_pulse,
    output logic                         fetch_req,
    output logic [AW-1:0]                fetch_vaddr,
    output logic [$clog2(FETCH_BYTES):0] fetch_len,
    output logic                         is_armed,
    output logic                         is_waiting,
    output logic                         wake_pending,
    output logic [AW-1:0]                line_addr
);
    localparam int LEN_W = $clog2(FETCH_BYTES) + 1;
    localparam logic [AW-1:0] OFF_MASK = AW'(LINE_BYTES - 1);

    mw_state_e     state_q;
    logic          armed_eff;
    logic          waiting_eff;
    logic          park_cmd;
    logic          hit;
    logic [AW-1:0] aligned_paddr;
    logic [AW-1:0] line_eff;
    logic [AW-1:0] vaddr_q;
    logic [AW-1:0] line_q;
    logic          pend_q;

    // A wait parks only when no wakeup is pending
    assign park_cmd = wait_valid & ~pend_q;

    mw_line_align #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_align (
        .byte_addr (wait_paddr),
        .line_base (aligned_paddr)
    );

    // Line seen by the snoop after monitor and wait
    always_comb begin
        line_eff = line_q;
        if (mon_valid) line_eff = '0;
        if (park_cmd)  line_eff = aligned_paddr;
    end

    mw_snoop_cmp #(.AW(AW)) u_cmp (
        .probe_valid (snoop_valid),
        .watch_live  (armed_eff & waiting_eff),
        .probe_addr  (snoop_addr),
        .watch_addr  (line_eff),
        .hit         (hit)
    );

    mw_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_cmd     (mon_valid),
        .park_cmd    (park_cmd),
        .wake_hit    (hit),
        .state_q     (state_q),
        .armed_eff   (armed_eff),
        .waiting_eff (waiting_eff)
    );

    // Address and pending storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            line_q  <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (mon_valid) vaddr_q <= mon_vaddr;
            line_q <= line_eff;
            if (hit)             pend_q <= 1'b1;
            else if (wait_valid) pend_q <= 1'b0;
        end
    end

    // Registered pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_req   <= 1'b0;
            wake_pulse <= 1'b0;
            fetch_req  <= 1'b0;
        end else begin
            halt_req   <= park_cmd;
            wake_pulse <= hit;
            fetch_req  <= wait_valid;
        end
    end

    assign fetch_vaddr  = vaddr_q;
    assign fetch_len    = LEN_W'(FETCH_BYTES);
    assign is_armed     = state_q[0];
    assign is_waiting   = state_q[1];
    assign wake_pending = pend_q;
    assign line_addr    = line_q;

    // Assertions
    assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    assert_wake_leaves_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (is_armed && !is_waiting));

    assert_wake_marks_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> wake_pending);

    assert_wake_needs_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> ($past(snoop_valid) && ($past(snoop_addr) == line_addr)));

    assert_halt_needs_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (!$past(wake_pending) && $past(wait_valid)));

    assert_halt_line_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> ((line_addr & OFF_MASK) == '0));
endmodule

// File: tb/mw_watch_unit_bench.sv
module mw_watch_unit_bench;
    localparam int AW = 48;
    localparam int LB = 64;
    localparam logic [AW-1:0] MASK = ~AW'(LB - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mon_valid = 1'b0, wait_valid = 1'b0, snoop_valid = 1'b0;
    logic [AW-1:0] mon_vaddr = '0, wait_paddr = '0, snoop_addr = '0;
    logic          halt_req, wake_pulse, fetch_req, is_armed, is_waiting, wake_pending;
    logic [AW-1:0] fetch_vaddr, line_addr;
    logic [3:0]    fetch_len;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Reference state
    bit            m_arm, m_wait, m_pend, m_halt, m_wake, m_fetch;
    logic [AW-1:0] m_vaddr, m_line;

    always #10 clk = ~clk;

    mw_watch_unit u_mw_watch_unit (
        .clk(clk), .rst_n(rst_n),
        .mon_valid(mon_valid), .mon_vaddr(mon_vaddr),
        .wait_valid(wait_valid), .wait_paddr(wait_paddr),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .halt_req(halt_req), .wake_pulse(wake_pulse), .fetch_req(fetch_req),
        .fetch_vaddr(fetch_vaddr), .fetch_len(fetch_len),
        .is_armed(is_armed), .is_waiting(is_waiting), .wake_pending(wake_pending),
        .line_addr(line_addr)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            mismatched++;
            $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic chk(input string what, input string tag,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk("halt_req",     tag, AW'(halt_req),     AW'(m_halt));
        chk("wake_pulse",   tag, AW'(wake_pulse),   AW'(m_wake));
        chk("fetch_req",    tag, AW'(fetch_req),    AW'(m_fetch));
        chk("fetch_vaddr",  tag, fetch_vaddr,       m_vaddr);
        chk("fetch_len",    tag, AW'(fetch_len),    AW'(8));
        chk("is_armed",     tag, AW'(is_armed),     AW'(m_arm));
        chk("is_waiting",   tag, AW'(is_waiting),   AW'(m_wait));
        chk("wake_pending", tag, AW'(wake_pending), AW'(m_pend));
        chk("line_addr",    tag, line_addr,         m_line);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        mon_valid = 0; wait_valid = 0; snoop_valid = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_arm = 0; m_wait = 0; m_pend = 0; m_halt = 0; m_wake = 0; m_fetch = 0;
        m_vaddr = '0; m_line = '0;
        compare_all(tag);
    endtask

    // One cycle: drive at negedge, model, check at next negedge
    task automatic step(input bit mv, input logic [AW-1:0] va,
                        input bit wv, input logic [AW-1:0] pa,
                        input bit sv, input logic [AW-1:0] sa, input string tag);
        mon_valid = mv; mon_vaddr = va;
        wait_valid = wv; wait_paddr = pa;
        snoop_valid = sv; snoop_addr = sa;
        m_halt = 0; m_wake = 0; m_fetch = wv;
        if (mv) begin m_arm = 1; m_vaddr = va; m_line = '0; end
        if (wv) begin
            if (!m_pend) begin m_line = pa & MASK; m_wait = 1; m_halt = 1; end
            else m_pend = 0;
        end
        if (sv && m_arm && m_wait && sa == m_line) begin
            m_wait = 0; m_pend = 1; m_wake = 1;
        end
        @(negedge clk);
        mon_valid = 0; wait_valid = 0; snoop_valid = 0;
        compare_all(tag);
    endtask

    initial begin
        logic [AW-1:0] pool [4];
        pool[0] = 48'h0; pool[1] = 48'h1_2340; pool[2] = 48'h1_2341; pool[3] = 48'h1_2380;

        do_reset("R1");
        step(1, 48'hABC0_1000, 0, 0, 0, 0, "R2");
        step(0, 0, 1, 48'h23_4567, 0, 0, "R4 R3 R10");
        step(0, 0, 0, 0, 0, 0, "R4 halt one cycle");
        step(0, 0, 0, 0, 1, 48'h23_4541, "R6 unaligned");
        step(0, 0, 0, 0, 1, 48'h23_4580, "R6 other line");
        step(0, 0, 0, 0, 0, 48'h23_4540, "R6 snoop_valid low");
        step(0, 0, 0, 0, 1, 48'h23_4540, "R7 R8 wake");
        step(0, 0, 0, 0, 0, 0, "R7 pulse one cycle");
        step(0, 0, 1, 48'h99_9999, 0, 0, "R5 consume pending");
        step(0, 0, 1, 48'h55_5500, 0, 0, "R4 park again");
        step(1, 48'h7700, 0, 0, 0, 0, "R2 monitor while sleeping");
        step(0, 0, 0, 0, 1, 48'h0, "R2 R7 zeroed line wakes");

        do_reset("R1 second");
        step(0, 0, 1, 48'h1_2345, 0, 0, "R4 unarmed wait");
        step(0, 0, 0, 0, 1, 48'h1_2340, "R6 unarmed no wake");
        step(1, 48'h40, 0, 0, 0, 0, "R2 arm parked");
        step(0, 0, 0, 0, 1, 48'h0, "R7 wake after arm");
        step(0, 0, 1, 48'h1_2345, 1, 48'h1_2340, "R9 wait+snoop pending set");
        step(0, 0, 1, 48'h1_2345, 1, 48'h1_2340, "R9 wait+snoop same cycle");
        step(0, 0, 1, 48'h0, 0, 0, "R5 consume");
        step(1, 48'h88, 1, 48'h2_0007, 1, 48'h2_0000, "R9 monitor wait snoop");
        step(0, 0, 1, 0, 0, 0, "R5 R10 fetch on consumed wait");

        for (int i = 0; i < 400; i++) begin
            step(($urandom % 8) == 0, AW'($urandom),
                 ($urandom % 3) == 0, pool[$urandom % 4] + AW'($urandom % 2),
                 ($urandom % 2) == 0, pool[$urandom % 4], "R6 R9 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule